// File: doc/BRIEF.md
# Low-Power DRAM Power-Up Sequencer

This block sits on the controller side of a low-power DRAM channel. It walks the device through its required power-up sequence: hold the clock enable low, wait through fixed NOP intervals, and issue the device reset. It then polls the device's auto-initialization status, hands off to an optional command-bus training engine, starts impedance calibration, and finally programs the three configuration mode registers. Every wait is a parameter counted in controller clock cycles. The sequence starts when the `start` input reports that supplies and clock are stable.

Commands go out on a simple port. `cmd_valid` carries a 2-bit opcode, an 8-bit mode-register address and an 8-bit write value. Each command stays presented until `cmd_ready` is sampled high, and the sequencer advances on that acceptance. Mode-register read results come back on `rsp_valid`/`rsp_data`. The physical encoding of commands onto the CA pins is left to a later stage. If a handshake stalls, a watchdog stops the sequence and raises a sticky error.

Top module: `lp_dram_boot_seq`

## Requirements
- R1: While reset is asserted, and after it until `start` is sampled high, cke, odt, cmd_valid, train_start, init_done and wdog_err are all low.
- R2: cke rises after max(T_INIT1, T_INIT2) cycles, counted from the clock edge that samples `start` high. From then on cke stays high and odt equals ODT_LEVEL.
- R3: For the first T_INIT3 cycles with cke high, cmd_valid is low.
- R4: Opcodes are: 1 = precharge all, 2 = mode-register write, 3 = mode-register read. When pre_all_en is high, one precharge-all precedes the reset write (opcode 2, address 0x3F, data 0xFC). Every command stays valid with stable fields until it is accepted, and the next step follows on the acceptance edge.
- R5: After the reset write is accepted, cmd_valid is low for T_INIT4 cycles. Then a mode-register read of address 0x00 is issued.
- R6: Bit 0 of a read response is the auto-initialization busy flag. A response with bit 0 = 1 leads to a new read of address 0x00. A response with bit 0 = 0 ends polling.
- R7: Polling ends at the end of the T_INIT5-th cycle after the reset write is accepted, even if no clearing response has arrived. A pending read is then withdrawn. A clearing response in that same cycle leads to the same single transition.
- R8: When train_req is high, polling is followed by train_start held high, with cmd_valid low, until train_done is sampled high.
- R9: Calibration is a write to address 0x0A with data 0xFF. After it is accepted, cmd_valid is low for T_ZQINIT cycles.
- R10: Writes to addresses 0x01, 0x02 and 0x03 follow, carrying MR1_VAL, MR2_VAL and MR3_VAL. Then init_done goes high and stays high with cmd_valid low.
- R11: If a command or the training handshake is not accepted within WDOG_CYCLES cycles, wdog_err goes high and stays high. cmd_valid and train_start are then low, and init_done never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Supplies and clock stable; begins the sequence |
| pre_all_en | input | 1 | Issue a precharge-all before the reset write |
| train_req | input | 1 | Command-bus training is required |
| train_done | input | 1 | Training engine finished |
| cmd_ready | input | 1 | Command port accepts the presented command |
| rsp_valid | input | 1 | Mode-register read result valid |
| rsp_data | input | 8 | Mode-register read result |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | Termination control level |
| cmd_valid | output | 1 | Command presented |
| cmd_op | output | 2 | Command opcode |
| cmd_ma | output | 8 | Mode-register address |
| cmd_wdata | output | 8 | Mode-register write value |
| train_start | output | 1 | Request to the training engine |
| init_done | output | 1 | Device ready for normal operation |
| wdog_err | output | 1 | Sequence stalled |

## Verification
Two events can fall in the same cycle: a status response with the busy flag clear, and the expiry of the maximum polling window. The bench provokes this with a responder that holds back its answer until the last cycle of the window, then returns a clear flag. A behavioural reference tracks the cycle index since the reset write. It expects exactly one exit from polling in that cycle, straight into the training handshake, with no further status read.

// File: rtl/lp_dram_boot_seq.sv
module lp_dram_boot_seq #(
  parameter int unsigned T_INIT1     = 80,
  parameter int unsigned T_INIT2     = 8,
  parameter int unsigned T_INIT3     = 160000,
  parameter int unsigned T_INIT4     = 800,
  parameter int unsigned T_INIT5     = 8000,
  parameter int unsigned T_ZQINIT    = 800,
  parameter int unsigned WDOG_CYCLES = 4096,
  parameter bit          ODT_LEVEL   = 1'b0,
  parameter logic [7:0]  MR1_VAL     = 8'h43,
  parameter logic [7:0]  MR2_VAL     = 8'h1A,
  parameter logic [7:0]  MR3_VAL     = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pre_all_en,
  input  logic       train_req,
  input  logic       train_done,
  input  logic       cmd_ready,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  output logic       cke,
  output logic       odt,
  output logic       cmd_valid,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_ma,
  output logic [7:0] cmd_wdata,
  output logic       train_start,
  output logic       init_done,
  output logic       wdog_err
);
  localparam int unsigned T_LOW = (T_INIT1 > T_INIT2) ? T_INIT1 : T_INIT2;
  localparam int unsigned M1    = (T_LOW > T_INIT3) ? T_LOW : T_INIT3;
  localparam int unsigned M2    = (M1 > T_INIT4) ? M1 : T_INIT4;
  localparam int unsigned M3    = (M2 > T_ZQINIT) ? M2 : T_ZQINIT;
  localparam int unsigned MAXT  = (M3 > WDOG_CYCLES) ? M3 : WDOG_CYCLES;
  localparam int CW = $clog2(MAXT + 1);
  localparam int FW = $clog2(T_INIT5 + 1);

  localparam logic [1:0] OP_PREA = 2'd1, OP_MRW = 2'd2, OP_MRR = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_LOW, S_NOP3, S_PREA, S_RST, S_NOP4, S_POLL, S_PWAIT,
    S_TRAIN, S_ZQ, S_ZQW, S_MR1, S_MR2, S_MR3, S_DONE, S_ERR
  } st_e;

  st_e st, nx, post;
  logic [CW-1:0] cnt, lim;
  logic [FW-1:0] win;
  logic hit, win_end, dai_clear, in_poll;

  always_comb begin
    case (st)
      S_LOW:   lim = CW'(T_LOW - 1);
      S_NOP3:  lim = CW'(T_INIT3 - 1);
      S_NOP4:  lim = CW'(T_INIT4 - 1);
      S_ZQW:   lim = CW'(T_ZQINIT - 1);
      default: lim = CW'(WDOG_CYCLES - 1);
    endcase
  end

  assign hit       = (cnt == lim);
  assign win_end   = (win == FW'(T_INIT5 - 1));
  assign dai_clear = rsp_valid && !rsp_data[0];
  assign post      = train_req ? S_TRAIN : S_ZQ;
  assign in_poll   = (st == S_NOP4) || (st == S_POLL) || (st == S_PWAIT);

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  if (start) nx = S_LOW;
      S_LOW:   if (hit) nx = S_NOP3;
      S_NOP3:  if (hit) nx = pre_all_en ? S_PREA : S_RST;
      S_PREA:  if (cmd_ready) nx = S_RST;  else if (hit) nx = S_ERR;
      S_RST:   if (cmd_ready) nx = S_NOP4; else if (hit) nx = S_ERR;
      S_NOP4:  if (hit) nx = win_end ? post : S_POLL;
      S_POLL:  if (win_end) nx = post; else if (cmd_ready) nx = S_PWAIT;
      S_PWAIT: if (win_end || dai_clear) nx = post; else if (rsp_valid) nx = S_POLL;
      S_TRAIN: if (train_done) nx = S_ZQ;  else if (hit) nx = S_ERR;
      S_ZQ:    if (cmd_ready) nx = S_ZQW;  else if (hit) nx = S_ERR;
      S_ZQW:   if (hit) nx = S_MR1;
      S_MR1:   if (cmd_ready) nx = S_MR2;  else if (hit) nx = S_ERR;
      S_MR2:   if (cmd_ready) nx = S_MR3;  else if (hit) nx = S_ERR;
      S_MR3:   if (cmd_ready) nx = S_DONE; else if (hit) nx = S_ERR;
      default: nx = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= nx;
      cnt <= (nx != st) ? '0 : cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         win <= '0;
    else if (st == S_RST && cmd_ready)  win <= '0;
    else if (in_poll && !win_end)       win <= win + FW'(1);
  end

  assign cke         = (st != S_IDLE) && (st != S_LOW);
  assign odt         = cke ? ODT_LEVEL : 1'b0;
  assign train_start = (st == S_TRAIN);
  assign init_done   = (st == S_DONE);
  assign wdog_err    = (st == S_ERR);
  assign cmd_valid   = (st == S_PREA) || (st == S_RST) || (st == S_POLL) || (st == S_ZQ) ||
                       (st == S_MR1) || (st == S_MR2) || (st == S_MR3);

  always_comb begin
    case (st)
      S_PREA:  {cmd_op, cmd_ma, cmd_wdata} = {OP_PREA, 8'h00, 8'h00};
      S_RST:   {cmd_op, cmd_ma, cmd_wdata} = {OP_MRW, 8'h3F, 8'hFC};
      S_POLL:  {cmd_op, cmd_ma, cmd_wdata} = {OP_MRR, 8'h00, 8'h00};
      S_ZQ:    {cmd_op, cmd_ma, cmd_wdata} = {OP_MRW, 8'h0A, 8'hFF};
      S_MR1:   {cmd_op, cmd_ma, cmd_wdata} = {OP_MRW, 8'h01, MR1_VAL};
      S_MR2:   {cmd_op, cmd_ma, cmd_wdata} = {OP_MRW, 8'h02, MR2_VAL};
      S_MR3:   {cmd_op, cmd_ma, cmd_wdata} = {OP_MRW, 8'h03, MR3_VAL};
      default: {cmd_op, cmd_ma, cmd_wdata} = '0;
    endcase
  end

  p_cke_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  p_quiet_low_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !cmd_valid);
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && cmd_op != OP_MRR) |=>
      ((cmd_valid && $stable(cmd_op) && $stable(cmd_ma) && $stable(cmd_wdata)) || wdog_err));
  p_train_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |-> !cmd_valid);
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && !cmd_valid));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_err |=> (wdog_err && !cmd_valid && !train_start && !init_done));
endmodule

// File: tb/lp_dram_boot_seq_tb_top.sv
module lp_dram_boot_seq_tb_top;
  localparam int T1 = 5, T2 = 8, T3 = 6, T4 = 4, T5 = 40, TZQ = 7, WD = 20;
  localparam int TLOW = (T1 > T2) ? T1 : T2;
  localparam bit ODTL = 1'b1;
  localparam logic [7:0] V1 = 8'h5A, V2 = 8'h1C, V3 = 8'h03;

  logic clk = 0, rst_n = 0, start = 0, pre_all_en = 0, train_req = 0, train_done = 0;
  logic cmd_ready = 0, rsp_valid = 0;
  logic [7:0] rsp_data = 0;
  logic cke, odt, cmd_valid, train_start, init_done, wdog_err;
  logic [1:0] cmd_op;
  logic [7:0] cmd_ma, cmd_wdata;

  lp_dram_boot_seq #(.T_INIT1(T1), .T_INIT2(T2), .T_INIT3(T3), .T_INIT4(T4), .T_INIT5(T5),
    .T_ZQINIT(TZQ), .WDOG_CYCLES(WD), .ODT_LEVEL(ODTL), .MR1_VAL(V1), .MR2_VAL(V2), .MR3_VAL(V3))
  dut_i (.clk(clk), .rst_n(rst_n), .start(start), .pre_all_en(pre_all_en), .train_req(train_req),
    .train_done(train_done), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cke(cke), .odt(odt), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ma(cmd_ma),
    .cmd_wdata(cmd_wdata), .train_start(train_start), .init_done(init_done), .wdog_err(wdog_err));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  string req = "R1";
  int rdy_mode = 0, rsp_mode = 0, busy_polls = 0, trn_mode = 0;
  logic e_cke, e_odt, e_valid, e_train, e_done, e_err;
  logic [1:0] e_op;
  logic [7:0] e_ma, e_wd;

  task automatic chk(string nm, logic [7:0] a, logic [7:0] e);
    compared++;
    if (a !== e) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, a, e, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("cke", 8'(cke), 8'(e_cke));
    chk("odt", 8'(odt), 8'(e_odt));
    chk("cmd_valid", 8'(cmd_valid), 8'(e_valid));
    chk("train_start", 8'(train_start), 8'(e_train));
    chk("init_done", 8'(init_done), 8'(e_done));
    chk("wdog_err", 8'(wdog_err), 8'(e_err));
    if (e_valid) begin
      chk("cmd_op", 8'(cmd_op), 8'(e_op));
      chk("cmd_ma", cmd_ma, e_ma);
      if (e_op == 2'd2) chk("cmd_wdata", cmd_wdata, e_wd);
    end
  endtask

  task automatic set_idle();
    {e_cke, e_odt, e_valid, e_train, e_done, e_err} = '0;
    e_op = 0; e_ma = 0; e_wd = 0;
  endtask

  task automatic set_cmd(logic [1:0] op, logic [7:0] ma, logic [7:0] wd);
    e_valid = 1; e_op = op; e_ma = ma; e_wd = wd;
  endtask

  task automatic to_err();
    req = "R11";
    e_valid = 0; e_train = 0; e_err = 1;
    repeat (4) cyc();
  endtask

  task automatic handshake(output bit ok);
    for (int i = 0; ; i++) begin
      cyc();
      if (cmd_ready) begin ok = 1; return; end
      if (i == WD - 1) begin ok = 0; return; end
    end
  endtask

  task automatic model();
    bit ok, leave;
    int c;
    do cyc(); while (!start);
    req = "R2"; repeat (TLOW) cyc();
    e_cke = 1; e_odt = ODTL;
    req = "R3"; repeat (T3) cyc();
    req = "R4";
    if (pre_all_en) begin
      set_cmd(2'd1, 8'h00, 8'h00);
      handshake(ok); if (!ok) begin to_err(); return; end
    end
    set_cmd(2'd2, 8'h3F, 8'hFC);
    handshake(ok); if (!ok) begin to_err(); return; end
    e_valid = 0; req = "R5"; c = 0;
    repeat (T4) begin cyc(); c++; end
    leave = (c - 1 >= T5 - 1);
    while (!leave) begin
      req = "R6 R7";
      set_cmd(2'd3, 8'h00, 8'h00);
      forever begin
        cyc(); c++;
        if (c - 1 >= T5 - 1) begin leave = 1; break; end
        if (cmd_ready) break;
      end
      if (leave) break;
      e_valid = 0;
      forever begin
        cyc(); c++;
        if (c - 1 >= T5 - 1 || (rsp_valid && !rsp_data[0])) begin leave = 1; break; end
        if (rsp_valid) break;
      end
    end
    e_valid = 0;
    if (train_req) begin
      req = "R8"; e_train = 1; ok = 0;
      for (int i = 0; i < WD; i++) begin
        cyc();
        if (train_done) begin ok = 1; break; end
      end
      if (!ok) begin to_err(); return; end
      e_train = 0;
    end
    req = "R9"; set_cmd(2'd2, 8'h0A, 8'hFF);
    handshake(ok); if (!ok) begin to_err(); return; end
    e_valid = 0; repeat (TZQ) cyc();
    req = "R10";
    set_cmd(2'd2, 8'h01, V1); handshake(ok); if (!ok) begin to_err(); return; end
    set_cmd(2'd2, 8'h02, V2); handshake(ok); if (!ok) begin to_err(); return; end
    set_cmd(2'd2, 8'h03, V3); handshake(ok); if (!ok) begin to_err(); return; end
    e_valid = 0; e_done = 1;
    repeat (4) cyc();
  endtask

  logic acc_rst = 0, acc_mrr = 0, trn_seen = 0;
  int tc = -1, wait_cnt = 0, polls = 0, tcnt = 0;

  always @(negedge clk) begin
    acc_rst  = cmd_valid && cmd_ready && cmd_op == 2'd2 && cmd_ma == 8'h3F;
    acc_mrr  = cmd_valid && cmd_ready && cmd_op == 2'd3;
    trn_seen = train_start;
  end

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: cmd_ready = 1;
      1: cmd_ready = ($urandom % 3) != 0;
      default: cmd_ready = 0;
    endcase
    rsp_valid = 0; rsp_data = 0;
    if (!rst_n) begin
      tc = -1; wait_cnt = 0; polls = 0; tcnt = 0; train_done = 0;
    end else begin
      if (acc_rst) tc = 0; else if (tc >= 0) tc++;
      if (rsp_mode == 0) begin
        if (wait_cnt > 0) begin
          wait_cnt--;
          if (wait_cnt == 0) begin
            rsp_valid = 1; rsp_data = (polls < busy_polls) ? 8'h01 : 8'h00; polls++;
          end
        end
        if (acc_mrr) wait_cnt = 2;
      end else if (tc == T5 - 1) begin
        rsp_valid = 1; rsp_data = 8'h00;
      end
      if (trn_seen) tcnt++; else tcnt = 0;
      train_done = (trn_mode == 0) && (tcnt >= 3);
    end
  end

  task automatic run(bit pre, bit trn, int rdy, int rspm, int busy, int trm);
    @(posedge clk); #2;
    rst_n = 0; start = 0;
    pre_all_en = pre; train_req = trn; rdy_mode = rdy; rsp_mode = rspm;
    busy_polls = busy; trn_mode = trm;
    set_idle(); req = "R1";
    cyc(); cyc();
    @(posedge clk); #2;
    rst_n = 1; start = 1;
    model();
  endtask

  initial begin
    run(1, 0, 0, 0, 2, 0);    // R4 R6 R10: precharge, two busy polls, no training
    run(0, 1, 1, 0, 1000, 0); // R7 R8: busy never clears, random ready
    run(1, 1, 0, 1, 0, 0);    // R7: clear response lands in the window-end cycle
    run(0, 1, 0, 0, 0, 1);    // R11: training never completes
    run(1, 0, 2, 0, 0, 0);    // R11: command port never ready
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule